// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

This block frees an I2C bus after a transfer was cut off partway and a slave is still holding SDA low. When a start request arrives, the block looks at the controller's busy indication and at the synchronised SDA line. If the bus is not busy and SDA is high, it reports completion at once and never touches the pins. Otherwise it takes ownership of the SCL pin and drives SCL low for one phase interval. It then issues clock pulses, one at a time. Before each pulse it samples SDA and stops as soon as the line is released, or once a bounded number of pulses has gone out.

After the last pulse it drives SCL high for one phase interval. It then hands the pins back to the normal controller and pulses a one-cycle done flag. A status output tells whether SDA was high at the end. The phase interval is a count of clock cycles. At 100 MHz the default is roughly one millisecond. SDA passes through a two-flop synchroniser before any decision uses it. The block does not generate a STOP condition and does not reset the controller.

Top module: `i2c_unstick`

## Requirements
- R1: After reset the block is idle: `pin_own_o` = 0, `scl_o` = 1, `done_o` = 0, `sda_free_o` = 0.
- R2: A start request seen while idle with `busy_i` = 0 and synchronised SDA = 1 gives `done_o` = 1 in the next cycle, with `pin_own_o` staying 0 and no SCL activity.
- R3: A start request seen while idle with `busy_i` = 1 or synchronised SDA = 0 sets `pin_own_o` = 1 in the next cycle. It then holds `scl_o` = 0 for exactly PHASE_CYC cycles.
- R4: At the end of each low interval SDA is sampled for one cycle with SCL still low. If it is 1, no further pulse is issued.
- R5: Each pulse drives `scl_o` = 1 for exactly PHASE_CYC cycles and then `scl_o` = 0 for exactly PHASE_CYC cycles.
- R6: No more than MAX_PULSES pulses (default 10) are issued in one recovery run.
- R7: When pulsing ends, `scl_o` is held at 1 for PHASE_CYC cycles with `pin_own_o` = 1. In the next cycle `done_o` = 1 for exactly one cycle and `pin_own_o` = 0.
- R8: `sda_free_o` takes the synchronised SDA value in the cycle `done_o` rises (1 = released) and holds it until the next completion.
- R9: Start requests that arrive while a run is in progress have no effect on the sequence.
- R10: SDA decisions use the input delayed by two clock cycles through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a recovery check (one cycle) |
| busy_i | input | 1 | Controller reports the bus busy |
| sda_i | input | 1 | Raw SDA pin level |
| scl_o | output | 1 | SCL level to drive while the block owns the pin |
| pin_own_o | output | 1 | 1 = block owns the pins, 0 = normal controller |
| done_o | output | 1 | One-cycle completion pulse |
| sda_free_o | output | 1 | SDA was high at completion |

## Verification
The assertions check properties that must hold in every cycle: SCL is high whenever the pins are not owned, done lasts one cycle and is never raised while the pins are owned, the pulse count never passes its cap, a high SDA sample always ends the pulsing, and a running sequence never falls back to idle without passing through completion. Other properties depend on how SDA behaves over a whole run, and only the bench's scenarios can show them. These are the exact length of each phase, how many pulses go out before SDA is released, the immediate finish on a free bus, the two-cycle synchroniser delay and the value latched into the status flag. A behavioural model is compared against every output on each clock.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_CHECK = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4,
    ST_TAIL  = 3'd5,
    ST_DONE  = 3'd6
  } rec_state_t;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int PHASE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (PHASE_CYC < 2) ? 1 : $clog2(PHASE_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import unstick_pkg::*;
#(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_s_i,
  input  logic phase_end_i,
  output logic load_o,
  output logic scl_o,
  output logic own_o,
  output logic done_o,
  output logic sda_free_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] CAP = PW'(MAX_PULSES);

  rec_state_t    st_q, st_d;
  logic [PW-1:0] pulses_q, pulses_d;
  logic          pulses_en;
  logic          free_q, free_d, free_en;

  always_comb begin
    st_d      = st_q;
    pulses_d  = pulses_q;
    pulses_en = 1'b0;
    free_d    = sda_s_i;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (busy_i || !sda_s_i) begin
            st_d      = ST_LEAD;
            pulses_d  = '0;
            pulses_en = 1'b1;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_LEAD:  if (phase_end_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (sda_s_i || (pulses_q == CAP)) begin
          st_d = ST_TAIL;
        end else begin
          st_d      = ST_HIGH;
          pulses_d  = pulses_q + 1'b1;
          pulses_en = 1'b1;
        end
      end
      ST_HIGH:  if (phase_end_i) st_d = ST_LOW;
      ST_LOW:   if (phase_end_i) st_d = ST_CHECK;
      ST_TAIL:  if (phase_end_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    free_en = (st_d == ST_DONE) && (st_q != ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pulses_q <= '0;
      free_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (pulses_en) pulses_q <= pulses_d;
      if (free_en)   free_q   <= free_d;
    end
  end

  always_comb begin
    load_o     = (st_d != st_q);
    own_o      = (st_q != ST_IDLE) && (st_q != ST_DONE);
    scl_o      = (st_q == ST_IDLE) || (st_q == ST_HIGH) ||
                 (st_q == ST_TAIL) || (st_q == ST_DONE);
    done_o     = (st_q == ST_DONE);
    sda_free_o = free_q;
  end

  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= CAP);
  p_stop_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && sda_s_i) |=> (st_q == ST_TAIL));
  p_no_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    own_o |=> (st_q != ST_IDLE));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
  parameter int PHASE_CYC   = 100000,
  parameter int MAX_PULSES  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  output logic scl_o,
  output logic pin_own_o,
  output logic done_o,
  output logic sda_free_o
);
  logic sda_s;
  logic phase_end;
  logic load;

  unstick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  unstick_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .expired_o(phase_end)
  );

  unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .sda_s_i(sda_s), .phase_end_i(phase_end), .load_o(load),
    .scl_o(scl_o), .own_o(pin_own_o), .done_o(done_o),
    .sda_free_o(sda_free_o)
  );

  p_released_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_own_o |-> scl_o);
  p_done_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pin_own_o);
endmodule

// File: tb/test_i2c_unstick.sv
module test_i2c_unstick;
  localparam int P   = 4;
  localparam int MAX = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_i = 1'b0;
  logic sda_i = 1'b1;
  logic scl_o, pin_own_o, done_o, sda_free_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  i2c_unstick #(.PHASE_CYC(P), .MAX_PULSES(MAX), .SYNC_STAGES(2)) i_i2c_unstick (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .sda_i(sda_i), .scl_o(scl_o), .pin_own_o(pin_own_o),
    .done_o(done_o), .sda_free_o(sda_free_o)
  );

  // behavioural model: phases 0 idle,1 lead,2 check,3 high,4 low,5 tail,6 done
  int   ph = 0, rem = 0, np = 0;
  bit   m_free = 0;
  bit   s1 = 1, s2 = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; rem = 0; np = 0; m_free = 0; s1 = 1; s2 = 1;
    end else begin
      case (ph)
        0: if (start_i) begin
             if (busy_i || !s2) begin ph = 1; rem = P; np = 0; end
             else begin ph = 6; m_free = s2; end
           end
        1, 3, 4, 5: begin
             rem--;
             if (rem == 0) begin
               if (ph == 1 || ph == 4) ph = 2;
               else if (ph == 3) begin ph = 4; rem = P; end
               else begin ph = 6; m_free = s2; end
             end
           end
        2: if (s2 || np == MAX) begin ph = 5; rem = P; end
           else begin np++; ph = 3; rem = P; end
        default: ph = 0;
      endcase
      s2 = s1; s1 = sda_i;   // R10: two-cycle delay
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R10 pin_own", pin_own_o, (ph >= 1 && ph <= 5));
      chk("R5/R4 scl", scl_o, (ph == 0 || ph == 3 || ph == 5 || ph == 6));
      chk("R7 done", done_o, (ph == 6));
      chk("R8 sda_free", sda_free_o, m_free);
    end
  end

  // run observation: rises of SCL while owned, falls, cycles owned
  int  rises = 0, falls = 0, owned = 0;
  bit  prev_scl = 1;
  int  release_at = 0;
  always @(negedge clk) begin
    if (pin_own_o && scl_o && !prev_scl) rises++;
    if (pin_own_o && !scl_o && prev_scl) begin
      falls++;
      if (release_at != 0 && falls == release_at) sda_i = 1'b1;
    end
    if (pin_own_o) owned++;
    prev_scl = scl_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input string tag, input bit busy, input bit sda,
                     input int rel, input int exp_pulses, input bit exp_free,
                     input bit poke);
    int waitc = 0;
    @(negedge clk);
    busy_i = busy; sda_i = sda; release_at = 0;
    repeat (3) @(negedge clk);
    rises = 0; falls = 0; owned = 0; release_at = rel;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!busy && sda) chk({tag, " R2 immediate done"}, done_o, 1);
    while (!done_o && waitc < 2000) begin
      @(negedge clk); waitc++;
      if (poke && waitc == 20) start_i = 1'b1;     // R9 mid-run request
      if (poke && waitc == 21) start_i = 1'b0;
    end
    chk({tag, " R6 pulses"}, (rises == 0) ? 0 : rises - 1, exp_pulses);
    chk({tag, " R8 free flag"}, sda_free_o, exp_free);
    chk({tag, " R7 released at done"}, pin_own_o, 0);
    if (!busy && sda) chk({tag, " R2 never owned"}, owned, 0);
    else chk({tag, " R5 owned cycles"}, owned,
             P + exp_pulses * (1 + 2 * P) + 1 + P);
    busy_i = 1'b0;
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset scl", scl_o, 1);
    chk("R1 reset own", pin_own_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset free", sda_free_o, 0);
    rst_n = 1'b1;
    run("free bus", 1'b0, 1'b1, 0, 0, 1'b1, 1'b0);
    run("busy sda high", 1'b1, 1'b1, 0, 0, 1'b1, 1'b0);
    run("release after 3", 1'b0, 1'b0, 4, 3, 1'b1, 1'b0);
    run("release after 1", 1'b1, 1'b0, 2, 1, 1'b1, 1'b0);
    run("stuck low R9", 1'b0, 1'b0, 0, MAX, 1'b0, 1'b1);
    sda_i = 1'b1;
    run("free again", 1'b0, 1'b1, 0, 0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule